// File: doc/BRIEF.md
# Multichannel Successive-Approximation Converter Sequencer

This block is the digital half of an eight-input, 12-bit successive-approximation converter. A small word-addressed register port configures it. The block divides the bus clock down to a conversion clock and selects the analog input through `sample_ch`. It drives the trial code on `dac_code` and reads back one comparator bit per step. Finished results go to a global result register and to a register for the source channel.

Conversions start in one of three ways: at once from software, on a chosen edge of one of six external trigger lines, or repeatedly in burst mode. Burst mode walks the channel mask and wraps around. The global result register carries a done flag and an overrun flag. Reading that register clears both flags. A control write clears done and restarts any conversion in flight.

Top module: `sar_scan_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00000001 and the global register (address 1) reads 0. Every channel register (addresses 2 to 9) also reads 0.
- R2: The control register fields are: mask in bits 7:0, divider N in bits 15:8, burst in bit 16, power in bit 21, start code in bits 26:24 and edge select in bit 27 (1 = falling). Every other bit reads back as 0.
- R3: A conversion lasts 13*(N+1) clock cycles, counted from the clock edge that starts it to the edge that sets done. Each conversion has one sample step and twelve bit steps, MSB first. A trial bit is kept when `cmp_in` is 1, so the result equals the input code of a comparator that reports input >= `dac_code`.
- R4: The global register holds the result in bits 15:4, the channel in bits 26:24, overrun in bit 30 and done in bit 31. All other bits are 0. Channel register 2+c holds the last result of channel c in bits 15:4 and has bit 31 set once that channel has been converted.
- R5: A read strobe on the global register clears done and overrun, unless a conversion completes in the same cycle.
- R6: Any control write clears done. A control write that arrives during a conversion abandons it and starts a new conversion on the new mask, unless the new value powers the block down.
- R7: Start code 001 starts one conversion at once, and the start field reads 000 after that conversion completes. Start code 000 starts nothing.
- R8: Start codes 010 to 111 start a conversion on the selected edge of trigger line code-2, after a two-flop synchronizer. Edges on the other trigger lines are ignored.
- R9: In burst mode, conversions repeat without software starts. The selected channels are converted in ascending order, wrapping to the lowest selected channel, and the start field is ignored.
- R10: In burst mode, overrun is set when a result completes while done is still set from an unread result.
- R11: While the power bit is 0, no conversion runs, whatever the start code or burst bit.
- R12: A non-burst conversion uses the lowest set mask bit. An all-zero mask selects channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe (with bus_sel), triggers read side effects |
| bus_addr | input | 4 | Word address: 0 control, 1 global, 2..9 channels |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Addressed register, combinational from bus_addr |
| trig_in | input | 6 | Asynchronous external start lines |
| cmp_in | input | 1 | Comparator: 1 when input >= dac_code |
| sample_ch | output | 3 | Analog multiplexer select |
| dac_code | output | 12 | Trial code for the comparator DAC |

## Verification
The assertions check on every cycle the following properties:
- the flag side effects of control writes and global reads;
- that a completion sets done;
- that nothing converts while the power bit is 0;
- that `sample_ch` always lies inside a non-zero mask while busy;
- that overrun only rises in burst mode.

Only the bench scenarios can show the following:
- the exact 13*(N+1) cycle latency and the binary-search result against modelled inputs;
- the wrap order of burst channels;
- the self-clearing immediate start;
- that edges on other trigger lines and the opposite edge of the selected line start nothing;
- the restart of an abandoned conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int NCH    = 8;
    localparam int CH_W   = $clog2(NCH);
    localparam int RES_W  = 12;
    localparam int DIV_W  = 8;
    localparam int NTRIG  = 6;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_GLOB = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CH0  = ADDR_W'(2);

    localparam logic [2:0] START_NONE = 3'd0;
    localparam logic [2:0] START_NOW  = 3'd1;
    localparam logic [2:0] START_TRG0 = 3'd2;

    typedef struct packed {
        logic             edge_fall;
        logic [2:0]       start;
        logic             pwr;
        logic             burst;
        logic [DIV_W-1:0] div;
        logic [NCH-1:0]   mask;
    } ctrl_t;

    function automatic logic [CH_W-1:0] first_ch(input logic [NCH-1:0] m);
        logic [CH_W-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) r = CH_W'(i);
        end
        return r;
    endfunction

    function automatic logic [CH_W-1:0] next_ch(input logic [NCH-1:0] m,
                                                input logic [CH_W-1:0] cur);
        logic [CH_W-1:0] r;
        logic            hit;
        r   = first_ch(m);
        hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (!hit && m[i] && (i > int'(cur))) begin
                r   = CH_W'(i);
                hit = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        cnt_d  = cnt_q + DIV_W'(1);
        if (restart_i || !run_i || tick_o) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sar_trig_edge.sv
module sar_trig_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig_i,
    input  logic         fall_i,
    output logic [N-1:0] edge_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = trig_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign edge_o[g] = fall_i ? (sy_q.s3[g] && !sy_q.s2[g])
                                  : (sy_q.s2[g] && !sy_q.s3[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  start_ch_i,
    input  logic             abort_i,
    input  logic             tick_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic [CH_W-1:0]  ch_o,
    output logic [RES_W-1:0] dac_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int IDX_W = $clog2(RES_W);

    typedef enum logic [1:0] {E_IDLE, E_SAMP, E_BITS} est_t;

    typedef struct packed {
        est_t             st;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] approx;
        logic [CH_W-1:0]  ch;
    } eng_t;

    eng_t e_d, e_q;
    logic [RES_W-1:0] trial;
    logic [RES_W-1:0] keep;

    always_comb begin
        trial    = RES_W'(1) << e_q.idx;
        dac_o    = (e_q.st == E_BITS) ? (e_q.approx | trial) : '0;
        keep     = cmp_i ? dac_o : e_q.approx;
        done_o   = tick_i && (e_q.st == E_BITS) && (e_q.idx == '0);
        result_o = keep;
        busy_o   = (e_q.st != E_IDLE);
        ch_o     = e_q.ch;

        e_d = e_q;
        if (start_i) begin
            e_d.st     = E_SAMP;
            e_d.ch     = start_ch_i;
            e_d.approx = '0;
            e_d.idx    = IDX_W'(RES_W - 1);
        end else if (abort_i) begin
            e_d.st = E_IDLE;
        end else if (tick_i) begin
            case (e_q.st)
                E_SAMP: begin
                    e_d.st     = E_BITS;
                    e_d.idx    = IDX_W'(RES_W - 1);
                    e_d.approx = '0;
                end
                E_BITS: begin
                    e_d.approx = keep;
                    if (e_q.idx == '0) e_d.st = E_IDLE;
                    else               e_d.idx = e_q.idx - IDX_W'(1);
                end
                default: e_d.st = E_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.st     <= E_IDLE;
            e_q.idx    <= '0;
            e_q.approx <= '0;
            e_q.ch     <= '0;
        end else begin
            e_q <= e_d;
        end
    end
endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl
    import sar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [5:0]  trig_in,
    input  logic        cmp_in,
    output logic [2:0]  sample_ch,
    output logic [11:0] dac_code
);
    typedef struct packed {
        ctrl_t                      ctrl;
        logic                       done;
        logic                       ovr;
        logic [RES_W-1:0]           g_res;
        logic [CH_W-1:0]            g_ch;
        logic [NCH-1:0][RES_W-1:0]  ch_res;
        logic [NCH-1:0]             ch_vld;
    } reg_t;

    reg_t r_d, r_q;

    logic             ctrl_wr, glob_rd;
    ctrl_t            wr_ctrl;
    logic             eng_start, eng_abort, eng_busy, eng_done, tick;
    logic [CH_W-1:0]  eng_start_ch, eng_ch;
    logic [RES_W-1:0] eng_res, eng_dac;
    logic [NTRIG-1:0] trig_edge;
    logic             trig_hit;
    logic [ADDR_W-1:0] ch_off;

    sar_trig_edge #(.N(NTRIG)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_in),
        .fall_i (r_q.ctrl.edge_fall),
        .edge_o (trig_edge)
    );

    sar_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (eng_busy),
        .restart_i (eng_start),
        .div_i     (r_q.ctrl.div),
        .tick_o    (tick)
    );

    sar_engine #(.RES_W(RES_W), .CH_W(CH_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (eng_start),
        .start_ch_i (eng_start_ch),
        .abort_i    (eng_abort),
        .tick_i     (tick),
        .cmp_i      (cmp_in),
        .busy_o     (eng_busy),
        .ch_o       (eng_ch),
        .dac_o      (eng_dac),
        .done_o     (eng_done),
        .result_o   (eng_res)
    );

    assign sample_ch = eng_ch;
    assign dac_code  = eng_dac;

    always_comb begin
        ctrl_wr = bus_sel && bus_wr && (bus_addr == A_CTRL);
        glob_rd = bus_sel && bus_rd && (bus_addr == A_GLOB);

        wr_ctrl.mask      = bus_wdata[7:0];
        wr_ctrl.div       = bus_wdata[15:8];
        wr_ctrl.burst     = bus_wdata[16];
        wr_ctrl.pwr       = bus_wdata[21];
        wr_ctrl.start     = bus_wdata[26:24];
        wr_ctrl.edge_fall = bus_wdata[27];

        trig_hit = (r_q.ctrl.start >= START_TRG0)
                   && trig_edge[r_q.ctrl.start - START_TRG0];

        // sequencing decisions
        eng_start    = 1'b0;
        eng_abort    = 1'b0;
        eng_start_ch = first_ch(r_q.ctrl.mask);
        if (ctrl_wr) begin
            eng_abort    = 1'b1;
            eng_start_ch = first_ch(wr_ctrl.mask);
            eng_start    = wr_ctrl.pwr && (wr_ctrl.burst || eng_busy
                                           || (wr_ctrl.start == START_NOW));
        end else if (r_q.ctrl.pwr) begin
            if (r_q.ctrl.burst) begin
                if (eng_done) begin
                    eng_start    = 1'b1;
                    eng_start_ch = next_ch(r_q.ctrl.mask, eng_ch);
                end else if (!eng_busy) begin
                    eng_start = 1'b1;
                end
            end else if (!eng_busy && trig_hit) begin
                eng_start = 1'b1;
            end
        end

        // register updates
        r_d = r_q;
        if (glob_rd) begin
            r_d.done = 1'b0;
            r_d.ovr  = 1'b0;
        end
        if (ctrl_wr) begin
            r_d.ctrl = wr_ctrl;
            r_d.done = 1'b0;
        end else if (eng_done) begin
            r_d.done           = 1'b1;
            r_d.ovr            = r_q.ovr || (r_q.ctrl.burst && r_q.done && !glob_rd);
            r_d.g_res          = eng_res;
            r_d.g_ch           = eng_ch;
            r_d.ch_res[eng_ch] = eng_res;
            r_d.ch_vld[eng_ch] = 1'b1;
            if (!r_q.ctrl.burst && (r_q.ctrl.start == START_NOW))
                r_d.ctrl.start = START_NONE;
        end

        // read mux
        ch_off    = bus_addr - A_CH0;
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata = {4'b0, r_q.ctrl.edge_fall, r_q.ctrl.start, 2'b0,
                         r_q.ctrl.pwr, 4'b0, r_q.ctrl.burst,
                         r_q.ctrl.div, r_q.ctrl.mask};
        end else if (bus_addr == A_GLOB) begin
            bus_rdata = {r_q.done, r_q.ovr, 3'b0, r_q.g_ch, 8'b0,
                         r_q.g_res, 4'b0};
        end else if ((bus_addr >= A_CH0) && (int'(ch_off) < NCH)) begin
            bus_rdata = {r_q.ch_vld[ch_off[CH_W-1:0]], 15'b0,
                         r_q.ch_res[ch_off[CH_W-1:0]], 4'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.ctrl.mask <= NCH'(1);
        end else begin
            r_q <= r_d;
        end
    end

    // observation points for the bound checker
    logic flag_done, flag_ovr, cfg_pwr, cfg_burst;
    logic [NCH-1:0] cfg_mask;
    assign flag_done = r_q.done;
    assign flag_ovr  = r_q.ovr;
    assign cfg_pwr   = r_q.ctrl.pwr;
    assign cfg_burst = r_q.ctrl.burst;
    assign cfg_mask  = r_q.ctrl.mask;
endmodule

// File: rtl/sar_scan_ctrl_chk.sv
module sar_scan_ctrl_chk #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_wr,
    input logic            glob_rd,
    input logic            conv_done,
    input logic            busy,
    input logic            done,
    input logic            ovr,
    input logic            pwr,
    input logic            burst,
    input logic [NCH-1:0]  mask,
    input logic [CH_W-1:0] sample_ch
);
    assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !ctrl_wr) |=> done);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_rd && !conv_done) |=> (!done && !ovr));

    assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !done);

    assert_chan_in_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mask != '0)) |-> mask[sample_ch]);

    assert_ovr_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(burst));

    assert_off_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |-> !busy);
endmodule

bind sar_scan_ctrl sar_scan_ctrl_chk #(.NCH(sar_pkg::NCH), .CH_W(sar_pkg::CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .glob_rd   (glob_rd),
    .conv_done (eng_done),
    .busy      (eng_busy),
    .done      (flag_done),
    .ovr       (flag_ovr),
    .pwr       (cfg_pwr),
    .burst     (cfg_burst),
    .mask      (cfg_mask),
    .sample_ch (sample_ch)
);

// File: tb/sar_scan_ctrl_tb.sv
`timescale 1ns/1ps
module sar_scan_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  trig_in = '0;
    logic        cmp_in;
    logic [2:0]  sample_ch;
    logic [11:0] dac_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [11:0] vin [8] = '{12'h000, 12'h5A3, 12'hFFF, 12'h800,
                             12'h7FF, 12'h123, 12'hABC, 12'h001};

    always #2 clk = ~clk;

    assign cmp_in = (vin[sample_ch] >= dac_code);

    sar_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .trig_in(trig_in), .cmp_in(cmp_in),
        .sample_ch(sample_ch), .dac_code(dac_code)
    );

    // {mask, div, expected channel}
    localparam logic [19:0] VEC [6] = '{
        {8'h01, 8'd0, 4'd0},
        {8'h20, 8'd0, 4'd5},
        {8'h0C, 8'd2, 4'd2},
        {8'h00, 8'd1, 4'd0},
        {8'h80, 8'd3, 4'd7},
        {8'h50, 8'd0, 4'd4}
    };

    localparam logic [31:0] PWR = 32'h0020_0000;
    localparam logic [31:0] NOW = 32'h0100_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done(input int maxc, output int n);
        bus_addr = 4'd1;
        n = 0;
        for (int i = 0; i < maxc; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            #1;
            if (bus_rdata[31]) break;
        end
    endtask

    function automatic logic [31:0] gexp(input logic [2:0] c, input logic ov);
        return {1'b1, ov, 3'b0, c, 8'b0, vin[c], 4'b0};
    endfunction

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        peek(4'd0, d); chk("R1 ctrl reset", d, 32'h0000_0001);
        peek(4'd1, d); chk("R1 global reset", d, 32'h0);
        peek(4'd4, d); chk("R1 channel reset", d, 32'h0);

        // R2 field layout, R11 powered down: start code and burst ignored
        wr(4'd0, 32'hFFD1_3CA5);
        peek(4'd0, d); chk("R2 ctrl readback", d, 32'h0F01_3CA5);
        repeat (80) @(posedge clk);
        peek(4'd1, d); chk("R11 no conversion while off", d, 32'h0);

        // table walk: R3 timing/result, R4 format, R5 clear, R7 self-clear, R12 channel pick
        for (int k = 0; k < 6; k++) begin
            logic [7:0] m; logic [7:0] dv; logic [2:0] c;
            m  = VEC[k][19:12];
            dv = VEC[k][11:4];
            c  = VEC[k][2:0];
            wr(4'd0, PWR | NOW | {16'b0, dv, m});
            wait_done(2000, n);
            chk("R3 latency", n, 13 * (int'(dv) + 1));
            rd(4'd1, d); chk("R4 R12 global word", d, gexp(c, 1'b0));
            peek(4'd1, d); chk("R5 done cleared by read", d[31:30], 2'b00);
            peek(4'd0, d); chk("R7 start self-clears", d[26:24], 3'b000);
            peek(4'd2 + 4'(c), d); chk("R4 channel register", d, {1'b1, 15'b0, vin[c], 4'b0});
        end

        // R7 start code 000 starts nothing
        wr(4'd0, PWR | 32'h0000_0002);
        repeat (60) @(posedge clk);
        peek(4'd1, d); chk("R7 no start", d[31], 1'b0);

        // R6 write clears done
        wr(4'd0, PWR | NOW | 32'h0000_0002);
        wait_done(100, n);
        chk("R6 setup done", bus_rdata[31], 1'b1);
        wr(4'd0, PWR | 32'h0000_0002);
        peek(4'd1, d); chk("R6 write clears done", d[31], 1'b0);

        // R6 write during conversion restarts on new mask
        wr(4'd0, PWR | NOW | 32'h0000_0302);
        repeat (20) @(posedge clk);
        wr(4'd0, PWR | 32'h0000_0008);
        wait_done(200, n);
        chk("R6 restart latency", n, 13);
        rd(4'd1, d); chk("R6 restarted channel", d, gexp(3'd3, 1'b0));

        // R8 rising edge on line 1 (code 3), line 0 ignored
        wr(4'd0, PWR | 32'h0300_0040);
        @(negedge clk) trig_in[0] = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk) trig_in[0] = 1'b0;
        repeat (30) @(posedge clk);
        peek(4'd1, d); chk("R8 other line ignored", d[31], 1'b0);
        @(negedge clk) trig_in[1] = 1'b1;
        wait_done(40, n);
        rd(4'd1, d); chk("R8 rising trigger", d, gexp(3'd6, 1'b0));
        @(negedge clk) trig_in[1] = 1'b0;

        // R8 falling edge on line 5 (code 7)
        wr(4'd0, PWR | 32'h0F00_0040);
        @(negedge clk) trig_in[5] = 1'b1;
        repeat (30) @(posedge clk);
        peek(4'd1, d); chk("R8 rising ignored in falling mode", d[31], 1'b0);
        @(negedge clk) trig_in[5] = 1'b0;
        wait_done(40, n);
        rd(4'd1, d); chk("R8 falling trigger", d, gexp(3'd6, 1'b0));

        // R9 burst order 1,2,5 with wrap; start code 000 present
        wr(4'd0, PWR | 32'h0001_0026);
        begin
            logic [2:0] seq [5] = '{3'd1, 3'd2, 3'd5, 3'd1, 3'd2};
            for (int j = 0; j < 5; j++) begin
                wait_done(40, n);
                rd(4'd1, d);
                chk("R9 burst channel order", d, gexp(seq[j], 1'b0));
            end
        end

        // R10 overrun when results go unread
        repeat (45) @(posedge clk);
        wr(4'd0, 32'h0000_0026);
        peek(4'd1, d); chk("R10 overrun set, done cleared by write", d[31:30], 2'b01);
        rd(4'd1, d);
        peek(4'd1, d); chk("R5 overrun cleared by read", d[31:30], 2'b00);
        repeat (40) @(posedge clk);
        peek(4'd1, d); chk("R11 burst stops when off", d[31], 1'b0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule